// File: doc/BRIEF.md
# Conditional Compare Flag Unit

This block keeps a four-bit condition flag register and updates it with flag-setting compare operations on two 64-bit operands. An operation either compares by subtraction or by addition, and either does so unconditionally or only when a condition, tested against the current flags, holds. When a conditional operation finds its condition false, the flags are loaded with a caller-supplied 4-bit immediate instead, so any flag pattern can be produced. A width select chooses between flags for a 32-bit or a 64-bit operation.

The flag vector is ordered {N, Z, C, V}, with N in bit 3 and V in bit 0. The operation select is encoded 0 = subtractive compare, 1 = additive compare, 2 = conditional subtractive compare, 3 = conditional additive compare. Subtraction uses true carry: C is set when no borrow occurs. The flags change only on a clock edge with the valid strobe high.

Top module: `cond_cmp_flags`

## Requirements
- R1: After reset the flag output is 4'b0000.
- R2: With valid low the flags hold their value regardless of every other input.
- R3: Operation 0 computes opA minus opB and sets N to the result sign bit, Z when the result is zero, C when no borrow occurs, V on signed overflow; 0 minus 0 gives 4'b0110 and 0 minus 1 gives 4'b1000.
- R4: Operation 1 computes opA plus opB with N, Z and V as in R3 and C as the unsigned carry out; 0 plus 0 gives 4'b0100.
- R5: With is64 low the flags come from the low 32 bits of both operands only (sign bit 31, carry out of bit 31); the upper 32 bits have no effect.
- R6: Operations 2 and 3 whose condition is true set the flags exactly as operations 0 and 1 respectively would.
- R7: Operations 2 and 3 whose condition is false load immFlags, bit 3 into N, bit 2 into Z, bit 1 into C, bit 0 into V.
- R8: Condition codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C and !Z, 9 !C or Z, 10 N==V, 11 N!=V, 12 !Z and N==V, 13 Z or N!=V; a conditional subtract on code 3 with immediate 0 starting from zeroed operands toggles C.
- R9: Condition codes 14 and 15 are both always true.
- R10: Operations 0 and 1 ignore condCode and immFlags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Perform the operation on this edge |
| opSel | input | 2 | Operation select (0 sub, 1 add, 2 cond sub, 3 cond add) |
| is64 | input | 1 | 1 = 64-bit flags, 0 = 32-bit flags |
| condCode | input | 4 | Condition for conditional operations |
| immFlags | input | 4 | Flags loaded when the condition fails, {N,Z,C,V} |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| flags | output | 4 | Current flags {N,Z,C,V} |

## Verification
The condition test and the flag update fall in the same cycle: a conditional operation reads the flags that the previous edge wrote and its outcome decides what the next edge writes. Back-to-back valid operations are driven with no idle cycle, both in a directed carry-toggle chain and in a long random stream, so every condition is judged against flags that were produced one cycle earlier. A bench model tracks the flags and predicts each next value from its own condition and arithmetic functions.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  typedef enum logic [1:0] {
    OP_SUB_CMP  = 2'd0,
    OP_ADD_CMP  = 2'd1,
    OP_COND_SUB = 2'd2,
    OP_COND_ADD = 2'd3
  } ccf_op_e;

  typedef struct packed {
    logic loadCmp;
    logic loadImm;
  } ccf_strobe_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/ccf_ctrl.sv
module ccf_ctrl
  import ccf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  ccf_op_e     opSel,
  input  logic [3:0]  condCode,
  input  logic [3:0]  flags,
  output ccf_strobe_t strobe,
  output logic        isSub
);
  logic fN, fZ, fC, fV;
  logic condHolds;
  logic isCond;

  assign fN = flags[FLAG_N];
  assign fZ = flags[FLAG_Z];
  assign fC = flags[FLAG_C];
  assign fV = flags[FLAG_V];

  always_comb begin
    unique case (condCode)
      4'd0:  condHolds = fZ;
      4'd1:  condHolds = !fZ;
      4'd2:  condHolds = fC;
      4'd3:  condHolds = !fC;
      4'd4:  condHolds = fN;
      4'd5:  condHolds = !fN;
      4'd6:  condHolds = fV;
      4'd7:  condHolds = !fV;
      4'd8:  condHolds = fC && !fZ;
      4'd9:  condHolds = !fC || fZ;
      4'd10: condHolds = (fN == fV);
      4'd11: condHolds = (fN != fV);
      4'd12: condHolds = !fZ && (fN == fV);
      4'd13: condHolds = fZ || (fN != fV);
      default: condHolds = 1'b1;
    endcase
  end

  assign isCond = (opSel == OP_COND_SUB) || (opSel == OP_COND_ADD);
  assign isSub  = (opSel == OP_SUB_CMP) || (opSel == OP_COND_SUB);

  always_comb begin
    strobe.loadCmp = valid && (!isCond || condHolds);
    strobe.loadImm = valid && isCond && !condHolds;
  end

  p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.loadCmp, strobe.loadImm}));
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !(strobe.loadCmp || strobe.loadImm));
  p_uncond_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !opSel[1] |-> strobe.loadCmp);
  p_never_true_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid && condCode == 4'd15 |-> !strobe.loadImm);
endmodule

// File: rtl/ccf_datapath.sv
module ccf_datapath
  import ccf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ccf_strobe_t       strobe,
  input  logic              isSub,
  input  logic              is64,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        immFlags,
  output logic [3:0]        flags
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sumWide;
  logic [HALF_W:0]   sumNarrow;
  logic [3:0]        cmpFlags;
  logic [3:0]        flagsNext;

  assign bEff = isSub ? ~opB : opB;
  assign sumWide   = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, isSub};
  assign sumNarrow = {1'b0, opA[HALF_W-1:0]} + {1'b0, bEff[HALF_W-1:0]}
                   + {{HALF_W{1'b0}}, isSub};

  always_comb begin
    if (is64) begin
      cmpFlags[FLAG_N] = sumWide[DATA_W-1];
      cmpFlags[FLAG_Z] = (sumWide[DATA_W-1:0] == '0);
      cmpFlags[FLAG_C] = sumWide[DATA_W];
      cmpFlags[FLAG_V] = (opA[DATA_W-1] == bEff[DATA_W-1])
                      && (sumWide[DATA_W-1] != opA[DATA_W-1]);
    end else begin
      cmpFlags[FLAG_N] = sumNarrow[HALF_W-1];
      cmpFlags[FLAG_Z] = (sumNarrow[HALF_W-1:0] == '0);
      cmpFlags[FLAG_C] = sumNarrow[HALF_W];
      cmpFlags[FLAG_V] = (opA[HALF_W-1] == bEff[HALF_W-1])
                      && (sumNarrow[HALF_W-1] != opA[HALF_W-1]);
    end
  end

  always_comb begin
    flagsNext = flags;
    if (strobe.loadCmp)      flagsNext = cmpFlags;
    else if (strobe.loadImm) flagsNext = immFlags;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= 4'b0000;
    else        flags <= flagsNext;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.loadCmp || strobe.loadImm) |=> $stable(flags));
  p_imm_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadImm |=> flags == $past(immFlags));
  p_sub_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadCmp && isSub && is64 && (opA == opB) |=> flags == 4'b0110);
  p_add_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadCmp && !isSub && (opA == '0) && (opB == '0) |=> flags == 4'b0100);
endmodule

// File: rtl/cond_cmp_flags.sv
module cond_cmp_flags
  import ccf_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [1:0]        opSel,
  input  logic              is64,
  input  logic [3:0]        condCode,
  input  logic [3:0]        immFlags,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [3:0]        flags
);
  ccf_strobe_t strobe;
  logic        isSub;

  ccf_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (valid),
    .opSel    (ccf_op_e'(opSel)),
    .condCode (condCode),
    .flags    (flags),
    .strobe   (strobe),
    .isSub    (isSub)
  );

  ccf_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .isSub    (isSub),
    .is64     (is64),
    .opA      (opA),
    .opB      (opB),
    .immFlags (immFlags),
    .flags    (flags)
  );
endmodule

// File: tb/test_cond_cmp_flags.sv
module test_cond_cmp_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic        is64 = 1'b1;
  logic [3:0]  condCode = 4'd0;
  logic [3:0]  immFlags = 4'd0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic [3:0]  flags;

  int testCount = 0;
  int failCount = 0;
  logic [3:0] model = 4'b0000;

  cond_cmp_flags i_cond_cmp_flags (
    .clk(clk), .rst_n(rst_n), .valid(valid), .opSel(opSel), .is64(is64),
    .condCode(condCode), .immFlags(immFlags), .opA(opA), .opB(opB), .flags(flags)
  );

  always #5 clk = ~clk;

  function automatic logic [3:0] refCompare(input logic [63:0] a, input logic [63:0] b,
                                            input logic sub, input logic w64);
    logic [64:0] full;
    logic [32:0] low;
    logic signed [64:0] sa, sb, sr;
    logic n, z, c, v;
    if (w64) begin
      full = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
      n = full[63];
      z = (full[63:0] == 64'd0);
      c = sub ? (a >= b) : full[64];
      sa = {a[63], a}; sb = {b[63], b};
      sr = sub ? sa - sb : sa + sb;
      v = (sr[64] != sr[63]);
    end else begin
      low = sub ? ({1'b0, a[31:0]} - {1'b0, b[31:0]}) : ({1'b0, a[31:0]} + {1'b0, b[31:0]});
      n = low[31];
      z = (low[31:0] == 32'd0);
      c = sub ? (a[31:0] >= b[31:0]) : low[32];
      sa = {{33{a[31]}}, a[31:0]}; sb = {{33{b[31]}}, b[31:0]};
      sr = sub ? sa - sb : sa + sb;
      v = (sr[32] != sr[31]);
    end
    return {n, z, c, v};
  endfunction

  function automatic logic refCond(input logic [3:0] f, input logic [3:0] cc);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'd0: return z;         4'd1: return !z;
      4'd2: return c;         4'd3: return !c;
      4'd4: return n;         4'd5: return !n;
      4'd6: return v;         4'd7: return !v;
      4'd8: return c & !z;    4'd9: return !(c & !z);
      4'd10: return n == v;   4'd11: return n != v;
      4'd12: return !z && n == v;
      4'd13: return !(!z && n == v);
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input logic [3:0] expv, input string tag);
    testCount++;
    if (flags !== expv) begin
      failCount++;
      $display("FAIL %s: flags=%b expected=%b", tag, flags, expv);
    end
  endtask

  task automatic doOp(input logic [1:0] op, input logic w64, input logic [3:0] cc,
                      input logic [3:0] imm, input logic [63:0] a, input logic [63:0] b,
                      input string tag);
    @(negedge clk);
    valid = 1'b1; opSel = op; is64 = w64; condCode = cc; immFlags = imm; opA = a; opB = b;
    if (op[1] && !refCond(model, cc)) model = imm;
    else model = refCompare(a, b, !op[0], w64);
    @(posedge clk); #1;
    check(model, tag);
  endtask

  initial begin
    #2_000_000;
    testCount++; failCount++;
    $display("FAIL watchdog: flags=%b expected=done", flags);
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(posedge clk);
    #1; check(4'b0000, "R1 reset");
    @(negedge clk); rst_n = 1'b1;

    doOp(2'd0, 1'b1, 4'd0, 4'd0, 64'd0, 64'd0, "R3 0-0");
    check(4'b0110, "R3 0-0 literal");
    doOp(2'd1, 1'b1, 4'd0, 4'd0, 64'd0, 64'd0, "R4 0+0");
    check(4'b0100, "R4 0+0 literal");
    doOp(2'd0, 1'b1, 4'd0, 4'd0, 64'd0, 64'd1, "R3 0-1");
    check(4'b1000, "R3 0-1 literal");
    doOp(2'd0, 1'b1, 4'd0, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R3 overflow");
    doOp(2'd1, 1'b1, 4'd0, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R4 carry out");

    // R8 carry toggle chain: C=0 -> cond sub on code 3 -> C=1 -> fails -> imm 0
    doOp(2'd1, 1'b1, 4'd0, 4'd0, 64'd0, 64'd0, "R4 clear C");
    doOp(2'd2, 1'b1, 4'd3, 4'd0, 64'd0, 64'd0, "R8 toggle C on");
    check(4'b0110, "R8 toggle C on literal");
    doOp(2'd2, 1'b1, 4'd3, 4'd0, 64'd0, 64'd0, "R8 toggle C off");
    check(4'b0000, "R8 toggle C off literal");

    // R7 arbitrary pattern: clear C then cond on CS fails
    doOp(2'd1, 1'b1, 4'd0, 4'd0, 64'd0, 64'd0, "R4 clear C again");
    doOp(2'd3, 1'b1, 4'd2, 4'b1101, 64'd5, 64'd9, "R7 imm pattern");
    check(4'b1101, "R7 imm literal");

    // R9 never code acts as always
    doOp(2'd2, 1'b1, 4'd15, 4'b1111, 64'd0, 64'd0, "R9 code 15");
    check(4'b0110, "R9 code 15 literal");
    doOp(2'd3, 1'b1, 4'd14, 4'b1111, 64'd0, 64'd0, "R9 code 14");

    // R10 unconditional ignores cond and imm
    doOp(2'd0, 1'b1, 4'd0, 4'b1011, 64'd3, 64'd7, "R10 cond ignored");

    // R5 upper bits ignored in 32-bit mode
    doOp(2'd0, 1'b0, 4'd0, 4'd0, 64'hABCD_0000_0000_0000, 64'h1234_0000_0000_0000, "R5 upper ignored");
    check(4'b0110, "R5 upper ignored literal");
    doOp(2'd1, 1'b0, 4'd0, 4'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, "R5 32-bit carry");
    check(4'b0111, "R5 32-bit carry literal");

    // R2 hold with valid low while inputs change
    @(negedge clk);
    valid = 1'b0; opSel = 2'd3; condCode = 4'd5; immFlags = 4'b1010; opA = 64'd1; opB = 64'd2;
    repeat (3) @(posedge clk);
    #1; check(model, "R2 hold");

    // Random stream, back-to-back
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] op;
      logic [63:0] a, b;
      op = 2'($urandom_range(0, 3));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom_range(0, 7) == 0) b = a;
      if ($urandom_range(0, 7) == 0) a[63:32] = {32{a[31]}};
      if (op[1]) doOp(op, 1'($urandom), 4'($urandom), 4'($urandom), a, b, "R6 R7 R8 random cond");
      else       doOp(op, 1'($urandom), 4'($urandom), 4'($urandom), a, b, "R3 R4 R5 random cmp");
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule